// File: doc/BRIEF.md
# Dual-Channel DAC Serial Command Front End

This block is the digital control path of a two-channel 10-bit voltage DAC. A host sends 16-bit command words over a three-wire serial link made of an active-low frame strobe, a serial clock and a data line. Each bit is captured on a falling edge of the serial clock while the frame strobe is low, with the most significant bit first. When the strobe returns high after exactly sixteen captured bits, the word is decoded into a channel select, a gain bit, a two-bit power-down code and a 10-bit output code. These values are written into the input holding stage of the selected channel.

Each channel is double-buffered. The values drive the outputs only when an active-low load strobe moves the holding stage of both channels into their output stage. An active-low clear drives both output codes to zero. The serial input word also leaves on a serial output, so that several devices can sit in one chain. All serial and strobe inputs are asynchronous to the block clock. They pass through synchronizers, which assumes a block clock at least four times the serial clock rate.

Top module: `dual_dac_ctrl`

## Requirements
- R1: Bit 15 of the command word picks the target channel: 0 writes channel A, 1 writes channel B. A valid frame changes the holding stage of that channel only.
- R2: The word is captured most significant bit first. Bit 14 is the gain bit, bits 13:12 are the power-down code (00 normal, 01/10/11 the three power-down loads), and bits 11:2 are the output code with bit 11 as its MSB. Bits 1:0 have no effect.
- R3: A valid frame with the load strobe held high leaves the output code, gain and power-down outputs of both channels unchanged.
- R4: While load_n is low, the output stage of both channels takes code, gain and power-down from its holding stage. A frame that completes while load_n stays low reaches the outputs without a new strobe.
- R5: A frame is taken only when exactly 16 serial-clock falling edges occur between the fall and the rise of the frame strobe. Frames with fewer or more edges change nothing.
- R6: After reset all output codes, gain bits and power-down codes are zero, the holding stages are zero, and the serial output is low.
- R7: While clear_n is low, both output codes are zero. Gain, power-down and the holding stages keep their values, so a later load restores the stored codes.
- R8: When clear_n and load_n are both low, clear wins and the output codes stay zero.
- R9: With chain_en high, ser_dout shows the bit captured 16 falling edges earlier. With chain_en low, ser_dout stays low.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| ser_frame_n | input | 1 | Active-low frame strobe of the serial link |
| ser_clk | input | 1 | Serial clock; data captured on its falling edge |
| ser_din | input | 1 | Serial data in |
| chain_en | input | 1 | Enables the chained serial output |
| ser_dout | output | 1 | Serial data out for chaining |
| load_n | input | 1 | Active-low load strobe moving both holding stages to the outputs |
| clear_n | input | 1 | Active-low clear of both output codes |
| code_a | output | 10 | Output code, channel A |
| code_b | output | 10 | Output code, channel B |
| gain_a | output | 1 | Gain bit, channel A |
| gain_b | output | 1 | Gain bit, channel B |
| pdmode_a | output | 2 | Power-down code, channel A |
| pdmode_b | output | 2 | Power-down code, channel B |

## Verification
The load strobe and the clear can be active in the same cycle. The bench holds both low together and expects zero codes for the whole overlap. It then releases clear with load still low and expects the stored codes to reappear. A frame commit can also land while load is held low. The bench completes a frame during a held load and expects the new code to reach the output without a further strobe, while the other channel keeps its value.

// File: rtl/dacif_pkg.sv
package dacif_pkg;
  parameter int CODE_W  = 10;
  parameter int FRAME_W = 16;
  parameter int PD_W    = 2;

  localparam int SEL_BIT  = FRAME_W - 1;
  localparam int GAIN_BIT = FRAME_W - 2;
  localparam int PD_TOP   = FRAME_W - 3;
  localparam int CODE_TOP = PD_TOP - PD_W;

  typedef struct packed {
    logic [PD_W-1:0]   pd;
    logic              gain;
    logic [CODE_W-1:0] code;
  } chan_cfg_t;
endpackage

// File: rtl/dacif_sync.sv
module dacif_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [STAGES-1:0][WIDTH-1:0] pipe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pipe_q <= {STAGES{RST_VAL}};
    end else begin
      pipe_q[0] <= d;
      for (int s = 1; s < STAGES; s++) pipe_q[s] <= pipe_q[s-1];
    end
  end

  assign q = pipe_q[STAGES-1];
endmodule

// File: rtl/dacif_deser.sv
module dacif_deser
  import dacif_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               frame_n,
  input  logic               sclk,
  input  logic               din,
  output logic               commit,
  output logic [FRAME_W-1:0] word,
  output logic               chain_bit
);
  localparam int CNT_W = $clog2(FRAME_W) + 1;
  localparam logic [CNT_W-1:0] CNT_MAX  = '1;
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);

  logic [FRAME_W-1:0] shift_q, shift_n;
  logic [CNT_W-1:0]   cnt_q, cnt_n;
  logic               sclk_q, frame_q;
  logic               fall, f_start, f_end;

  assign fall    = sclk_q & ~sclk;
  assign f_start = frame_q & ~frame_n;
  assign f_end   = ~frame_q & frame_n;

  always_comb begin
    shift_n = shift_q;
    cnt_n   = f_start ? '0 : cnt_q;
    if (!frame_n && fall) begin
      shift_n = {shift_q[FRAME_W-2:0], din};
      if (cnt_n != CNT_MAX) cnt_n = cnt_n + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shift_q <= '0;
      cnt_q   <= '0;
      sclk_q  <= 1'b0;
      frame_q <= 1'b1;
    end else begin
      shift_q <= shift_n;
      cnt_q   <= cnt_n;
      sclk_q  <= sclk;
      frame_q <= frame_n;
    end
  end

  assign commit    = f_end && (cnt_q == CNT_FULL);
  assign word      = shift_q;
  assign chain_bit = shift_q[FRAME_W-1];
endmodule

// File: rtl/dacif_chan.sv
module dacif_chan
  import dacif_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      wr_en,
  input  chan_cfg_t wr_cfg,
  input  logic      load,
  input  logic      clear,
  output chan_cfg_t hold_cfg,
  output chan_cfg_t out_cfg
);
  chan_cfg_t hold_q, hold_n, out_q, out_n;

  always_comb begin
    hold_n = wr_en ? wr_cfg : hold_q;
    out_n  = out_q;
    if (load) out_n = hold_q;
    if (clear) out_n.code = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
      out_q  <= '0;
    end else begin
      hold_q <= hold_n;
      out_q  <= out_n;
    end
  end

  assign hold_cfg = hold_q;
  assign out_cfg  = out_q;
endmodule

// File: rtl/dual_dac_ctrl.sv
module dual_dac_ctrl
  import dacif_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_frame_n,
  input  logic              ser_clk,
  input  logic              ser_din,
  input  logic              chain_en,
  output logic              ser_dout,
  input  logic              load_n,
  input  logic              clear_n,
  output logic [CODE_W-1:0] code_a,
  output logic [CODE_W-1:0] code_b,
  output logic              gain_a,
  output logic              gain_b,
  output logic [PD_W-1:0]   pdmode_a,
  output logic [PD_W-1:0]   pdmode_b
);
  localparam int NCH = 2;

  logic [4:0] raw_in, sync_out;
  logic frame_s, sclk_s, din_s, ld_act, clr_act;
  logic commit;
  logic [FRAME_W-1:0] word;
  logic chain_bit;
  chan_cfg_t wr_cfg;
  chan_cfg_t [NCH-1:0] hold_w, out_w;
  logic [NCH-1:0][CODE_W-1:0] hold_code_w;

  assign raw_in = {clear_n, load_n, ser_din, ser_clk, ser_frame_n};

  dacif_sync #(.WIDTH(5), .STAGES(SYNC_STAGES), .RST_VAL(5'b11011)) sync_i (
    .clk(clk), .rst_n(rst_n), .d(raw_in), .q(sync_out));

  assign frame_s = sync_out[0];
  assign sclk_s  = sync_out[1];
  assign din_s   = sync_out[2];
  assign ld_act  = ~sync_out[3];
  assign clr_act = ~sync_out[4];

  dacif_deser deser_i (
    .clk(clk), .rst_n(rst_n), .frame_n(frame_s), .sclk(sclk_s), .din(din_s),
    .commit(commit), .word(word), .chain_bit(chain_bit));

  assign wr_cfg.pd   = word[PD_TOP -: PD_W];
  assign wr_cfg.gain = word[GAIN_BIT];
  assign wr_cfg.code = word[CODE_TOP -: CODE_W];

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    dacif_chan chan_i (
      .clk(clk), .rst_n(rst_n),
      .wr_en(commit && (word[SEL_BIT] == c[0])),
      .wr_cfg(wr_cfg), .load(ld_act), .clear(clr_act),
      .hold_cfg(hold_w[c]), .out_cfg(out_w[c]));
    assign hold_code_w[c] = hold_w[c].code;
  end

  assign ser_dout = chain_en & chain_bit;
  assign code_a   = out_w[0].code;
  assign code_b   = out_w[1].code;
  assign gain_a   = out_w[0].gain;
  assign gain_b   = out_w[1].gain;
  assign pdmode_a = out_w[0].pd;
  assign pdmode_b = out_w[1].pd;
endmodule

// File: rtl/dual_dac_ctrl_chk.sv
module dual_dac_ctrl_chk
  import dacif_pkg::*;
(
  input logic                       clk,
  input logic                       rst_n,
  input logic                       commit,
  input logic                       ld_act,
  input logic                       clr_act,
  input logic [1:0][CODE_W-1:0]     hold_code,
  input logic [CODE_W-1:0]          code_a,
  input logic [CODE_W-1:0]          code_b
);
  p_load_copy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_act && !clr_act) |=> (code_a == $past(hold_code[0]) && code_b == $past(hold_code[1])));

  p_clear_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    clr_act |=> (code_a == '0 && code_b == '0));

  p_hold_outputs_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld_act && !clr_act) |=> ($stable(code_a) && $stable(code_b)));

  p_no_stray_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> $stable(hold_code));

  p_one_channel_r1: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> ($stable(hold_code[0]) || $stable(hold_code[1])));
endmodule

bind dual_dac_ctrl dual_dac_ctrl_chk chk_i (
  .clk(clk), .rst_n(rst_n), .commit(commit), .ld_act(ld_act), .clr_act(clr_act),
  .hold_code(hold_code_w), .code_a(code_a), .code_b(code_b));

// File: tb/dual_dac_ctrl_tb.sv
module dual_dac_ctrl_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ser_frame_n = 1'b1, ser_clk = 1'b1, ser_din = 1'b0;
  logic chain_en = 1'b0, load_n = 1'b1, clear_n = 1'b1;
  logic ser_dout;
  logic [9:0] code_a, code_b;
  logic gain_a, gain_b;
  logic [1:0] pdmode_a, pdmode_b;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  dual_dac_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .ser_frame_n(ser_frame_n), .ser_clk(ser_clk),
    .ser_din(ser_din), .chain_en(chain_en), .ser_dout(ser_dout),
    .load_n(load_n), .clear_n(clear_n), .code_a(code_a), .code_b(code_b),
    .gain_a(gain_a), .gain_b(gain_b), .pdmode_a(pdmode_a), .pdmode_b(pdmode_b));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic check_ch(input string req, input bit b, input logic [9:0] c,
                          input logic g, input logic [1:0] p);
    if (!b) begin
      check(req, code_a, c); check(req, gain_a, g); check(req, pdmode_a, p);
    end else begin
      check(req, code_b, c); check(req, gain_b, g); check(req, pdmode_b, p);
    end
  endtask

  function automatic logic [15:0] mk(input bit b, input bit g, input logic [1:0] p,
                                     input logic [9:0] c, input logic [1:0] lsb);
    return {b, g, p, c, lsb};
  endfunction

  task automatic bit_out(input logic v);
    ser_din = v; #24; ser_clk = 1'b0; #24; ser_clk = 1'b1;
  endtask

  task automatic send(input logic [15:0] w, input int nbits);
    ser_frame_n = 1'b0; #48;
    for (int i = 0; i < nbits; i++) bit_out(w[15 - (i % 16)]);
    #48; ser_frame_n = 1'b1; #96;
  endtask

  task automatic pulse_load;
    load_n = 1'b0; #48; load_n = 1'b1; #48;
  endtask

  task automatic t_reset;
    check_ch("R6 reset A", 0, 10'd0, 1'b0, 2'd0);
    check_ch("R6 reset B", 1, 10'd0, 1'b0, 2'd0);
    check("R6 dout", ser_dout, 1'b0);
  endtask

  task automatic t_double_buffer;
    send(mk(0, 1, 2'b01, 10'h2A5, 2'b00), 16);
    check_ch("R3 no load A", 0, 10'd0, 1'b0, 2'd0);
    pulse_load;
    check_ch("R4 R2 load A", 0, 10'h2A5, 1'b1, 2'b01);
    check_ch("R1 B untouched", 1, 10'd0, 1'b0, 2'd0);
  endtask

  task automatic t_chan_b;
    send(mk(1, 0, 2'b10, 10'h3FF, 2'b11), 16);
    pulse_load;
    check_ch("R1 write B", 1, 10'h3FF, 1'b0, 2'b10);
    check_ch("R1 A kept", 0, 10'h2A5, 1'b1, 2'b01);
    send(mk(1, 1, 2'b11, 10'h155, 2'b01), 16);
    send(mk(1, 1, 2'b00, 10'h001, 2'b10), 16);
    pulse_load;
    check_ch("R2 lsb ignored", 1, 10'h001, 1'b1, 2'b00);
  endtask

  task automatic t_bad_frames;
    send(mk(0, 0, 2'b11, 10'h0F0, 2'b00), 15);
    pulse_load;
    check_ch("R5 short frame", 0, 10'h2A5, 1'b1, 2'b01);
    send(mk(0, 0, 2'b11, 10'h0F0, 2'b00), 17);
    pulse_load;
    check_ch("R5 long frame", 0, 10'h2A5, 1'b1, 2'b01);
  endtask

  task automatic t_clear;
    clear_n = 1'b0; #48;
    check("R7 clear A", code_a, 10'd0);
    check("R7 clear B", code_b, 10'd0);
    check("R7 pd kept", pdmode_a, 2'b01);
    load_n = 1'b0; #48;
    check("R8 clear over load A", code_a, 10'd0);
    check("R8 clear over load B", code_b, 10'd0);
    clear_n = 1'b1; #48;
    check("R7 restore A", code_a, 10'h2A5);
    check("R7 restore B", code_b, 10'h001);
    send(mk(0, 0, 2'b10, 10'h123, 2'b00), 16);
    check_ch("R4 held load pass", 0, 10'h123, 1'b0, 2'b10);
    check("R4 held load B", code_b, 10'h001);
    load_n = 1'b1; #48;
  endtask

  task automatic t_chain;
    logic [15:0] w1, got;
    w1 = 16'hB3C5;
    got = '0;
    ser_frame_n = 1'b0; #48;
    for (int i = 0; i < 16; i++) bit_out(w1[15 - i]);
    for (int i = 0; i < 16; i++) begin
      ser_din = 1'b0; #16;
      got[15 - i] = ser_dout;
      #8; ser_clk = 1'b0; #24; ser_clk = 1'b1;
    end
    check("R9 chain word", got, w1);
    #48; ser_frame_n = 1'b1; #96;
    pulse_load;
    check("R5 32-bit frame", code_a, 10'h123);
    chain_en = 1'b0;
    send(16'hFFFF, 16);
    check("R9 chain off", ser_dout, 1'b0);
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #20; @(negedge clk); rst_n = 1'b1; #48;
    t_reset;
    t_double_buffer;
    t_chan_b;
    t_bad_frames;
    t_clear;
    chain_en = 1'b1;
    t_chain;
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule